// File: doc/BRIEF.md
# Branch direction and target predictor

This block gives a fetch stage one prediction per cycle for a processor that runs up to eight hardware contexts. Each lookup carries an instruction address, a context number and an instruction kind. The block answers with a taken/not-taken guess and, where it can, a predicted target address. The answer comes out on the next clock edge.

Conditional branches are predicted from a shared table of 2-bit saturating counters. The table is direct-mapped on address bits and has no tags, so branches that land on the same entry share one counter. Every context has its own return address stack. Call lookups push onto that stack and return lookups pop from it. Computed jumps are predicted from a small direct-mapped table that keeps the last target seen for each jump address. A stored tag must match before that target is used.

Resolved outcomes come back on a separate update port. The update port can be active in the same cycle as a lookup. The tables are independent of the instruction cache, so any address can be predicted.

Top module: `bpred_top`

## Requirements
- R1: The kind code is 2 bits: 0 conditional branch, 1 call, 2 return, 3 computed jump. After reset every direction counter holds 1 (weakly not-taken), so a conditional branch lookup predicts not-taken. Counter values 2 and 3 predict taken.
- R2: A branch update (kind 0) with taken set increments the counter at instruction address bits [12:2], saturating at 3. A branch update with taken clear decrements it. Branch lookups never present a valid target.
- R3: Counters saturate at 0. From 0, one taken update gives 1, which still predicts not-taken.
- R4: The direction table stores no tag. Two branch addresses that are equal in bits [12:2] share one counter.
- R5: For a lookup in cycle n, the prediction is presented in cycle n+1 with pr_valid high. In a cycle that follows no lookup, pr_valid, pr_taken and pr_tgt_valid are all low.
- R6: A call lookup pushes its address plus 4 onto the stack of its context. It predicts taken with no valid target.
- R7: A return lookup pops the stack of its context and predicts taken. Its target is the most recently pushed address that has not yet been popped, with the target marked valid.
- R8: A return lookup on an empty stack predicts taken with the target marked invalid.
- R9: Each stack holds 12 entries. A push onto a full stack overwrites the oldest entry. After 13 pushes, 12 pops return the newest 12 values in reverse order, and the 13th pop is invalid.
- R10: The return stacks of different contexts are independent.
- R11: A jump-table entry is picked by address bits [6:2] and tagged with bits [31:7]. A jump update (kind 3) writes the tag and target into its entry. A jump lookup is valid only when the tag matches, and a new tag at the same entry replaces the old one.
- R12: An update that writes the entry being read in the same cycle is not visible to that read. It is visible to the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Lookup instruction address |
| lk_ctx | input | 3 | Lookup context number |
| lk_kind | input | 2 | Lookup instruction kind |
| up_valid | input | 1 | Update request |
| up_pc | input | 32 | Address of the resolved instruction |
| up_kind | input | 2 | Kind of the resolved instruction |
| up_taken | input | 1 | Resolved branch direction |
| up_target | input | 32 | Resolved jump target |
| pr_valid | output | 1 | Prediction present |
| pr_taken | output | 1 | Predicted taken |
| pr_tgt_valid | output | 1 | Predicted target is usable |
| pr_tgt | output | 32 | Predicted target address |

## Verification
A corrupted direction counter shows up at the next lookup of any branch that maps to that entry. It appears as a wrong pr_taken one cycle after that lookup. An off-by-one stack pointer or count shows up on the first return after a call: the target is wrong or falsely marked valid. Overflow wrap errors appear only after the 13th push and the following run of pops. A wrong jump-table tag or index produces a false hit or a false miss on the first jump lookup after an update. Same-cycle forwarding would flip the prediction made in the very cycle of the update.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
   typedef enum logic [1:0] {
      KIND_BRANCH = 2'd0,
      KIND_CALL   = 2'd1,
      KIND_RETURN = 2'd2,
      KIND_JUMP   = 2'd3
   } br_kind_e;

   localparam logic [1:0] CTR_RESET = 2'd1;
   localparam logic [1:0] CTR_MAX   = 2'd3;
endpackage

// File: rtl/bpred_dir_table.sv
module bpred_dir_table #(
   parameter int ENTRIES = 2048,
   localparam int IW = $clog2(ENTRIES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_idx,
   output logic          rd_taken,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic          wr_taken
);
   import bpred_pkg::*;

   logic [1:0] ctr [ENTRIES];
   logic [1:0] cur, nxt;

   assign rd_taken = ctr[rd_idx][1];
   assign cur      = ctr[wr_idx];

   always_comb begin
      nxt = cur;
      if (wr_taken && cur != CTR_MAX) nxt = cur + 2'd1;
      else if (!wr_taken && cur != 2'd0) nxt = cur - 2'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) ctr[i] <= CTR_RESET;
      end else if (wr_en) begin
         ctr[wr_idx] <= nxt;
      end
   end
endmodule

// File: rtl/bpred_ras.sv
module bpred_ras #(
   parameter int DEPTH = 12,
   parameter int AW    = 32,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic          pop,
   output logic          nonempty,
   output logic [AW-1:0] top_addr
);
   logic [AW-1:0] mem [DEPTH];
   logic [PW-1:0] ptr, top_idx;
   logic [CW-1:0] cnt;

   assign top_idx  = (ptr == '0) ? PW'(DEPTH - 1) : ptr - PW'(1);
   assign nonempty = (cnt != '0);
   assign top_addr = mem[top_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
         cnt <= '0;
      end else if (push) begin
         ptr <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + PW'(1);
         if (cnt != CW'(DEPTH)) cnt <= cnt + CW'(1);
      end else if (pop && nonempty) begin
         ptr <= top_idx;
         cnt <= cnt - CW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[ptr] <= push_addr;
   end
endmodule

// File: rtl/bpred_jump_table.sv
module bpred_jump_table #(
   parameter int ENTRIES = 32,
   parameter int AW      = 32,
   localparam int IW = $clog2(ENTRIES),
   localparam int TW = AW - IW - 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_pc,
   output logic          rd_hit,
   output logic [AW-1:0] rd_tgt,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_pc,
   input  logic [AW-1:0] wr_tgt
);
   logic [ENTRIES-1:0] vld;
   logic [TW-1:0]      tag [ENTRIES];
   logic [AW-1:0]      tgt [ENTRIES];
   logic [IW-1:0]      ri, wi;
   logic [1:0]         unused_lo;

   assign ri        = rd_pc[IW+1:2];
   assign wi        = wr_pc[IW+1:2];
   assign unused_lo = rd_pc[1:0] ^ wr_pc[1:0];
   assign rd_hit    = vld[ri] && (tag[ri] == rd_pc[AW-1:IW+2]);
   assign rd_tgt    = tgt[ri];

   always_ff @(posedge clk) begin
      if (!rst_n) vld <= '0;
      else if (wr_en) vld[wi] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag[wi] <= wr_pc[AW-1:IW+2];
         tgt[wi] <= wr_tgt;
      end
   end
endmodule

// File: rtl/bpred_top.sv
module bpred_top #(
   parameter int PC_W        = 32,
   parameter int NUM_CTX     = 8,
   parameter int DIR_ENTRIES = 2048,
   parameter int RAS_DEPTH   = 12,
   parameter int JT_ENTRIES  = 32,
   localparam int CTX_W  = $clog2(NUM_CTX),
   localparam int DIR_IW = $clog2(DIR_ENTRIES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lk_valid,
   input  logic [PC_W-1:0] lk_pc,
   input  logic [CTX_W-1:0] lk_ctx,
   input  logic [1:0]      lk_kind,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic [1:0]      up_kind,
   input  logic            up_taken,
   input  logic [PC_W-1:0] up_target,
   output logic            pr_valid,
   output logic            pr_taken,
   output logic            pr_tgt_valid,
   output logic [PC_W-1:0] pr_tgt
);
   import bpred_pkg::*;

   initial begin
      assert ((1 << DIR_IW) == DIR_ENTRIES) else $error("DIR_ENTRIES must be a power of two");
      assert (JT_ENTRIES == (1 << $clog2(JT_ENTRIES))) else $error("JT_ENTRIES must be a power of two");
      assert (RAS_DEPTH >= 2) else $error("RAS_DEPTH too small");
      assert (PC_W > DIR_IW + 2) else $error("PC_W too narrow");
   end

   br_kind_e lk_k, up_k;
   assign lk_k = br_kind_e'(lk_kind);
   assign up_k = br_kind_e'(up_kind);

   logic            dir_taken;
   logic            jt_hit;
   logic [PC_W-1:0] jt_tgt;
   logic [NUM_CTX-1:0] ras_ne;
   logic [PC_W-1:0] ras_top [NUM_CTX];
   logic [PC_W-1:0] ret_addr;
   logic [1:0]      unused_up_lo;

   assign ret_addr     = lk_pc + PC_W'(4);
   assign unused_up_lo = up_pc[1:0];

   bpred_dir_table #(.ENTRIES(DIR_ENTRIES)) u_dir (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_pc[DIR_IW+1:2]),
      .rd_taken(dir_taken),
      .wr_en   (up_valid && up_k == KIND_BRANCH),
      .wr_idx  (up_pc[DIR_IW+1:2]),
      .wr_taken(up_taken)
   );

   bpred_jump_table #(.ENTRIES(JT_ENTRIES), .AW(PC_W)) u_jt (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_pc (lk_pc),
      .rd_hit(jt_hit),
      .rd_tgt(jt_tgt),
      .wr_en (up_valid && up_k == KIND_JUMP),
      .wr_pc (up_pc),
      .wr_tgt(up_target)
   );

   for (genvar g = 0; g < NUM_CTX; g++) begin : g_ras
      logic sel;
      assign sel = lk_valid && (lk_ctx == CTX_W'(g));
      bpred_ras #(.DEPTH(RAS_DEPTH), .AW(PC_W)) u_ras (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (sel && lk_k == KIND_CALL),
         .push_addr(ret_addr),
         .pop      (sel && lk_k == KIND_RETURN),
         .nonempty (ras_ne[g]),
         .top_addr (ras_top[g])
      );
   end

   logic            n_taken, n_tv;
   logic [PC_W-1:0] n_tgt;

   always_comb begin
      n_taken = 1'b1;
      n_tv    = 1'b0;
      n_tgt   = '0;
      unique case (lk_k)
         KIND_BRANCH: n_taken = dir_taken;
         KIND_CALL:   n_tv    = 1'b0;
         KIND_RETURN: begin
            n_tv  = ras_ne[lk_ctx];
            n_tgt = ras_top[lk_ctx];
         end
         KIND_JUMP: begin
            n_tv  = jt_hit;
            n_tgt = jt_tgt;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !lk_valid) begin
         pr_valid     <= 1'b0;
         pr_taken     <= 1'b0;
         pr_tgt_valid <= 1'b0;
         pr_tgt       <= '0;
      end else begin
         pr_valid     <= 1'b1;
         pr_taken     <= n_taken;
         pr_tgt_valid <= n_tv;
         pr_tgt       <= n_tv ? n_tgt : '0;
      end
   end
endmodule

// File: rtl/bpred_chk.sv
module bpred_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       lk_valid,
   input logic [1:0] lk_kind,
   input logic       pr_valid,
   input logic       pr_taken,
   input logic       pr_tgt_valid
);
   AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> pr_valid);                                            // R5
   AST_IDLE_NO_PRED: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !pr_valid);                                          // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !pr_valid |-> (!pr_taken && !pr_tgt_valid));                       // R5
   AST_BRANCH_NO_TGT: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_kind == 2'd0) |=> !pr_tgt_valid);                  // R2
   AST_CALL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_kind == 2'd1) |=> (pr_taken && !pr_tgt_valid));    // R6
   AST_RETURN_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_kind == 2'd2) |=> pr_taken);                       // R7
endmodule

bind bpred_top bpred_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lk_valid    (lk_valid),
   .lk_kind     (lk_kind),
   .pr_valid    (pr_valid),
   .pr_taken    (pr_taken),
   .pr_tgt_valid(pr_tgt_valid)
);

// File: tb/bpred_top_tb.sv
`timescale 1ns/1ps
module bpred_top_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        lk_valid;
   logic [31:0] lk_pc;
   logic [2:0]  lk_ctx;
   logic [1:0]  lk_kind;
   logic        up_valid;
   logic [31:0] up_pc;
   logic [1:0]  up_kind;
   logic        up_taken;
   logic [31:0] up_target;
   logic        pr_valid, pr_taken, pr_tgt_valid;
   logic [31:0] pr_tgt;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   bpred_top u_dut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      lk_valid = 1'b0;
      up_valid = 1'b0;
   endtask

   // drive one lookup; results are on the outputs at the following negedge
   task automatic look(input logic [31:0] pc, input logic [2:0] ctx, input logic [1:0] kind);
      @(negedge clk);
      lk_valid = 1'b1; lk_pc = pc; lk_ctx = ctx; lk_kind = kind;
      up_valid = 1'b0;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic upd(input logic [31:0] pc, input logic [1:0] kind, input logic tk, input logic [31:0] tgt);
      @(negedge clk);
      up_valid = 1'b1; up_pc = pc; up_kind = kind; up_taken = tk; up_target = tgt;
      lk_valid = 1'b0;
      @(negedge clk);
      up_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R5 reset pr_valid", {31'd0, pr_valid}, 32'd0);
      look(32'h0000_0100, 3'd0, 2'd0);
      chk("R5 valid after lookup", {31'd0, pr_valid}, 32'd1);
      chk("R1 reset predicts not-taken", {31'd0, pr_taken}, 32'd0);
      chk("R2 branch has no target", {31'd0, pr_tgt_valid}, 32'd0);
      idle();
      chk("R5 idle cycle quiet", {29'd0, pr_valid, pr_taken, pr_tgt_valid}, 32'd0);
   endtask

   task automatic t_counter();
      upd(32'h0000_0200, 2'd0, 1'b1, 32'd0);   // 1 -> 2
      look(32'h0000_0200, 3'd0, 2'd0);
      chk("R1 counter 2 predicts taken", {31'd0, pr_taken}, 32'd1);
      for (int i = 0; i < 4; i++) upd(32'h0000_0200, 2'd0, 1'b1, 32'd0); // sat 3
      upd(32'h0000_0200, 2'd0, 1'b0, 32'd0);   // 3 -> 2
      look(32'h0000_0200, 3'd0, 2'd0);
      chk("R2 saturated at 3 then one not-taken", {31'd0, pr_taken}, 32'd1);
      upd(32'h0000_0200, 2'd0, 1'b0, 32'd0);   // 2 -> 1
      look(32'h0000_0200, 3'd0, 2'd0);
      chk("R2 decrement to 1", {31'd0, pr_taken}, 32'd0);
      for (int i = 0; i < 4; i++) upd(32'h0000_0200, 2'd0, 1'b0, 32'd0); // sat 0
      upd(32'h0000_0200, 2'd0, 1'b1, 32'd0);   // 0 -> 1
      look(32'h0000_0200, 3'd0, 2'd0);
      chk("R3 saturated at 0", {31'd0, pr_taken}, 32'd0);
   endtask

   task automatic t_alias();
      upd(32'h0000_0104, 2'd0, 1'b1, 32'd0);
      look(32'h0000_2104, 3'd5, 2'd0);
      chk("R4 alias shares counter", {31'd0, pr_taken}, 32'd1);
   endtask

   task automatic t_ras_basic();
      look(32'h0000_1000, 3'd1, 2'd1);
      chk("R6 call taken", {31'd0, pr_taken}, 32'd1);
      chk("R6 call no target", {31'd0, pr_tgt_valid}, 32'd0);
      look(32'h0000_2000, 3'd1, 2'd1);
      look(32'h0000_0000, 3'd2, 2'd2);
      chk("R10 other context empty", {31'd0, pr_tgt_valid}, 32'd0);
      chk("R8 empty return taken", {31'd0, pr_taken}, 32'd1);
      look(32'h0000_0000, 3'd1, 2'd2);
      chk("R7 pop newest valid", {31'd0, pr_tgt_valid}, 32'd1);
      chk("R7 pop newest", pr_tgt, 32'h0000_2004);
      look(32'h0000_0000, 3'd1, 2'd2);
      chk("R7 pop older", pr_tgt, 32'h0000_1004);
      look(32'h0000_0000, 3'd1, 2'd2);
      chk("R8 empty after pops", {31'd0, pr_tgt_valid}, 32'd0);
   endtask

   task automatic t_ras_overflow();
      for (int i = 0; i < 13; i++) look(32'h0000_4000 + 32'(i * 16), 3'd3, 2'd1);
      for (int i = 12; i >= 1; i--) begin
         look(32'h0, 3'd3, 2'd2);
         chk("R9 overflow pop order", {pr_tgt_valid, pr_tgt[30:0]},
             {1'b1, 31'(32'h0000_4004 + 32'(i * 16))});
      end
      look(32'h0, 3'd3, 2'd2);
      chk("R9 13th pop invalid", {31'd0, pr_tgt_valid}, 32'd0);
   endtask

   task automatic t_jump();
      look(32'h0000_0400, 3'd0, 2'd3);
      chk("R11 cold miss", {31'd0, pr_tgt_valid}, 32'd0);
      upd(32'h0000_0400, 2'd3, 1'b1, 32'h0000_8000);
      look(32'h0000_0400, 3'd4, 2'd3);
      chk("R11 hit valid", {31'd0, pr_tgt_valid}, 32'd1);
      chk("R11 hit target", pr_tgt, 32'h0000_8000);
      look(32'h0000_0480, 3'd0, 2'd3);
      chk("R11 tag mismatch miss", {31'd0, pr_tgt_valid}, 32'd0);
      upd(32'h0000_0480, 2'd3, 1'b1, 32'h0000_9000);
      look(32'h0000_0400, 3'd0, 2'd3);
      chk("R11 replaced entry misses", {31'd0, pr_tgt_valid}, 32'd0);
      look(32'h0000_0480, 3'd0, 2'd3);
      chk("R11 new tag hits", pr_tgt, 32'h0000_9000);
   endtask

   task automatic t_same_cycle();
      @(negedge clk);
      lk_valid = 1'b1; lk_pc = 32'h0000_0300; lk_ctx = 3'd0; lk_kind = 2'd0;
      up_valid = 1'b1; up_pc = 32'h0000_0300; up_kind = 2'd0; up_taken = 1'b1;
      @(negedge clk);
      lk_valid = 1'b0; up_valid = 1'b0;
      chk("R12 no forwarding", {31'd0, pr_taken}, 32'd0);
      look(32'h0000_0300, 3'd0, 2'd0);
      chk("R12 visible next lookup", {31'd0, pr_taken}, 32'd1);
      @(negedge clk);
      lk_valid = 1'b1; lk_pc = 32'h0000_0500; lk_kind = 2'd3;
      up_valid = 1'b1; up_pc = 32'h0000_0500; up_kind = 2'd3; up_target = 32'h0000_A000;
      @(negedge clk);
      lk_valid = 1'b0; up_valid = 1'b0;
      chk("R12 jump no forwarding", {31'd0, pr_tgt_valid}, 32'd0);
   endtask

   initial begin
      rst_n = 1'b0; lk_valid = 1'b0; lk_pc = '0; lk_ctx = '0; lk_kind = '0;
      up_valid = 1'b0; up_pc = '0; up_kind = '0; up_taken = 1'b0; up_target = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_counter();
      t_alias();
      t_ras_basic();
      t_ras_overflow();
      t_jump();
      t_same_cycle();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #100000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule